// File: doc/BRIEF.md
# Inverting bidirectional latched bus transceiver

This block connects two 8-bit ports, called A and B, through two independent storage banks. One bank carries data from A towards B, the other from B towards A. Each direction has three active-low controls: a direction select, a capture control and an output control. The capture control decides whether the bank follows its source port or keeps what it already holds. The output control decides whether the opposite port is driven. The direction select gates both of these. Data is complemented on the way through, in both directions.

Each port is modelled as an input bus, an output bus and a drive flag, so the block synthesizes without tri-state pins. Storage is built as clocked registers. While a bank is open, it loads its source on every rising clock edge. When its capture control goes high, the bank keeps the value loaded on the last edge at which it was open. Each output is combinational from its bank and its controls. A new value therefore appears on the opposite port one clock after it is presented. A change in the drive flags shows up at once. After reset both banks hold zero.

Top module: `xcvr_inv_latch`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears both banks to all zeros. A direction whose select and output controls are then both low drives all ones (8'hFF).
- R2: When a direction's select and capture controls are both low at a rising clock edge, that bank loads its source port: a_in for the A-to-B bank, b_in for the B-to-A bank.
- R3: When the capture control is high at an edge, the bank keeps the value loaded at the last edge at which select and capture were both low. It does not follow its source.
- R4: When the direction select is high at an edge, the bank keeps its value whatever the capture control and the source port show.
- R5: A port's drive flag (b_drive for A-to-B, a_drive for B-to-A) is 1 exactly when that direction's select and output controls are both low. The flag follows these controls with no clock delay. While the flag is 0, the port's output bus is all zeros.
- R6: While driven, a port's output bus is the bitwise complement of the bank that feeds it.
- R7: The two directions are independent. The controls and data of one direction never change the other direction's bank, drive flag or output bus.
- R8: The output control does not affect storage. A bank keeps its value while its port is released, and presents the same value when driving is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; banks load on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both banks |
| ab_sel_n | input | 1 | A-to-B direction select, active low |
| ab_cap_n | input | 1 | A-to-B capture control, active low (low = follow a_in) |
| ab_oe_n | input | 1 | A-to-B output control, active low |
| ba_sel_n | input | 1 | B-to-A direction select, active low |
| ba_cap_n | input | 1 | B-to-A capture control, active low (low = follow b_in) |
| ba_oe_n | input | 1 | B-to-A output control, active low |
| a_in | input | 8 | Value present on the A port |
| b_in | input | 8 | Value present on the B port |
| a_out | output | 8 | Value the block drives onto A (zero when released) |
| a_drive | output | 1 | High when the block drives the A port |
| b_out | output | 8 | Value the block drives onto B (zero when released) |
| b_drive | output | 1 | High when the block drives the B port |

## Verification
Assertions check on every cycle that an open bank loads its source one edge later, and that a closed bank stays stable. They also check that a released port outputs zeros, and that a driven port shows the complement of its bank. The bench scenarios cover the behaviours that need a history. These are: holding a value through a rising capture control, keeping data across a released period and showing it again, the all-ones output right after reset, and the absence of any effect of one direction on the other.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    BANK_HOLD = 1'b0,
    BANK_OPEN = 1'b1
  } bank_mode_e;

  // Bank follows its source only when select and capture are both low.
  function automatic bank_mode_e bank_mode(input logic sel_n, input logic cap_n);
    return (!sel_n && !cap_n) ? BANK_OPEN : BANK_HOLD;
  endfunction

  // Opposite port is driven only when select and output control are both low.
  function automatic logic port_driven(input logic sel_n, input logic oe_n);
    return !(sel_n || oe_n);
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] held
);

  logic [WIDTH-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= src;
    end
  end

  assign held = held_q;

  AST_BANK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (held == $past(src))); // R2

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(held)); // R3

endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] held,
  input  logic             enable,
  output logic [WIDTH-1:0] port_out,
  output logic             port_drive
);

  always_comb begin
    port_drive = enable;
    port_out   = enable ? ~held : '0;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             cap_n,
  input  logic             oe_n,
  input  logic [WIDTH-1:0] src,
  output logic [WIDTH-1:0] dst_out,
  output logic             dst_drive
);

  bank_mode_e       mode_w;
  logic             load_w;
  logic             drive_en_w;
  logic [WIDTH-1:0] held_w;

  assign mode_w     = bank_mode(sel_n, cap_n);
  assign load_w     = (mode_w == BANK_OPEN);
  assign drive_en_w = port_driven(sel_n, oe_n);

  xcvr_store #(.WIDTH(WIDTH)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_w),
    .src   (src),
    .held  (held_w)
  );

  xcvr_drive #(.WIDTH(WIDTH)) i_drive (
    .held       (held_w),
    .enable     (drive_en_w),
    .port_out   (dst_out),
    .port_drive (dst_drive)
  );

  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_drive |-> (dst_out == '0)); // R5

  AST_DRIVEN_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    dst_drive |-> ((dst_out ^ held_w) == {WIDTH{1'b1}})); // R6

  AST_OE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_n && $changed(oe_n)) |=> $stable(held_w)); // R8

endmodule

// File: rtl/xcvr_inv_latch.sv
module xcvr_inv_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_sel_n,
  input  logic             ab_cap_n,
  input  logic             ab_oe_n,
  input  logic             ba_sel_n,
  input  logic             ba_cap_n,
  input  logic             ba_oe_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive
);

  localparam int LANES = 2;

  logic [LANES-1:0]            sel_n_v, cap_n_v, oe_n_v, drv_v;
  logic [LANES-1:0][WIDTH-1:0] src_v, out_v;

  // Lane 0 carries A to B, lane 1 carries B to A.
  assign sel_n_v = {ba_sel_n, ab_sel_n};
  assign cap_n_v = {ba_cap_n, ab_cap_n};
  assign oe_n_v  = {ba_oe_n,  ab_oe_n};
  assign src_v   = {b_in, a_in};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xcvr_lane #(.WIDTH(WIDTH)) i_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_n     (sel_n_v[g]),
      .cap_n     (cap_n_v[g]),
      .oe_n      (oe_n_v[g]),
      .src       (src_v[g]),
      .dst_out   (out_v[g]),
      .dst_drive (drv_v[g])
    );
  end

  assign b_out   = out_v[0];
  assign b_drive = drv_v[0];
  assign a_out   = out_v[1];
  assign a_drive = drv_v[1];

  AST_BA_IDLE_NO_A: assert property (@(posedge clk) disable iff (!rst_n)
    ba_sel_n |-> !a_drive); // R7

endmodule

// File: tb/test_xcvr_inv_latch.sv
module test_xcvr_inv_latch;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  typedef struct packed {
    logic       ab_sel, ab_cap, ab_oe;
    logic [7:0] a;
    logic       ba_sel, ba_cap, ba_oe;
    logic [7:0] b;
    logic       exp_bdrv;
    logic [7:0] exp_bout;
    logic       exp_adrv;
    logic [7:0] exp_aout;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,8'h3C, 1'b1,1'b1,1'b1,8'h00, 1'b1,8'hC3, 1'b0,8'h00, 4'd2}, // R2 load
    '{1'b0,1'b0,1'b0,8'hA5, 1'b1,1'b1,1'b1,8'h00, 1'b1,8'h5A, 1'b0,8'h00, 4'd6}, // R6 complement
    '{1'b0,1'b1,1'b0,8'hFF, 1'b1,1'b1,1'b1,8'h00, 1'b1,8'h5A, 1'b0,8'h00, 4'd3}, // R3 hold
    '{1'b0,1'b1,1'b0,8'h00, 1'b1,1'b1,1'b1,8'h00, 1'b1,8'h5A, 1'b0,8'h00, 4'd3}, // R3 hold
    '{1'b1,1'b0,1'b0,8'h11, 1'b1,1'b1,1'b1,8'h00, 1'b0,8'h00, 1'b0,8'h00, 4'd5}, // R5 sel high
    '{1'b0,1'b1,1'b1,8'h22, 1'b1,1'b1,1'b1,8'h00, 1'b0,8'h00, 1'b0,8'h00, 4'd8}, // R8 released
    '{1'b0,1'b1,1'b0,8'h33, 1'b1,1'b1,1'b1,8'h00, 1'b1,8'h5A, 1'b0,8'h00, 4'd8}, // R8 re-enabled
    '{1'b0,1'b1,1'b1,8'h44, 1'b0,1'b0,1'b0,8'h0F, 1'b0,8'h00, 1'b1,8'hF0, 4'd7}, // R7 B to A
    '{1'b0,1'b0,1'b1,8'h81, 1'b0,1'b1,1'b1,8'hFF, 1'b0,8'h00, 1'b0,8'h00, 4'd7}, // R7 A loads alone
    '{1'b0,1'b1,1'b0,8'h00, 1'b1,1'b0,1'b0,8'h55, 1'b1,8'h7E, 1'b0,8'h00, 4'd4}, // R4 sel high
    '{1'b0,1'b1,1'b0,8'h00, 1'b0,1'b1,1'b0,8'h55, 1'b1,8'h7E, 1'b1,8'hF0, 4'd4}  // R4 kept
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic ab_sel_n = 1'b1, ab_cap_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_sel_n = 1'b1, ba_cap_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_drive, b_drive;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_inv_latch #(.WIDTH(W)) i_xcvr_inv_latch (
    .clk(clk), .rst_n(rst_n),
    .ab_sel_n(ab_sel_n), .ab_cap_n(ab_cap_n), .ab_oe_n(ab_oe_n),
    .ba_sel_n(ba_sel_n), .ba_cap_n(ba_cap_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .a_drive(a_drive), .b_out(b_out), .b_drive(b_drive)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_ports(input string tag, input logic bd, input logic [W-1:0] bo,
                             input logic ad, input logic [W-1:0] ao);
    check({tag, " b_drive"}, {7'd0, b_drive}, {7'd0, bd});
    check({tag, " b_out"},   b_out, bo);
    check({tag, " a_drive"}, {7'd0, a_drive}, {7'd0, ad});
    check({tag, " a_out"},   a_out, ao);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ab_sel_n = 1'b1; ab_cap_n = 1'b1; ab_oe_n = 1'b1;
    ba_sel_n = 1'b1; ba_cap_n = 1'b1; ba_oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    check_ports("R5 after reset all released", 1'b0, 8'h00, 1'b0, 8'h00);

    // R1: enable both outputs without any capture -> all ones
    ab_sel_n = 1'b0; ab_oe_n = 1'b0; ba_sel_n = 1'b0; ba_oe_n = 1'b0;
    a_in = 8'h5C; b_in = 8'hC5;
    @(posedge clk); #2;
    check_ports("R1 cleared banks drive ones", 1'b1, 8'hFF, 1'b1, 8'hFF);

    @(negedge clk);
    ba_sel_n = 1'b1; ba_oe_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ab_sel_n = VECS[i].ab_sel; ab_cap_n = VECS[i].ab_cap; ab_oe_n = VECS[i].ab_oe;
      a_in = VECS[i].a;
      ba_sel_n = VECS[i].ba_sel; ba_cap_n = VECS[i].ba_cap; ba_oe_n = VECS[i].ba_oe;
      b_in = VECS[i].b;
      @(posedge clk); #2;
      check_ports($sformatf("R%0d vector %0d", VECS[i].req, i),
                  VECS[i].exp_bdrv, VECS[i].exp_bout, VECS[i].exp_adrv, VECS[i].exp_aout);
    end

    // R5: drive flag drops at once when output control rises, no clock needed
    @(negedge clk);
    ab_oe_n = 1'b1;
    #1;
    check("R5 immediate release b_drive", {7'd0, b_drive}, 8'h00);
    check("R5 released b_out zero", b_out, 8'h00);
    ab_oe_n = 1'b0;
    #1;
    check("R8 immediate re-drive b_out", b_out, 8'h7E);

    // R1: mid-run reset clears stored data
    do_reset();
    ab_sel_n = 1'b0; ab_oe_n = 1'b0; ab_cap_n = 1'b1;
    ba_sel_n = 1'b0; ba_oe_n = 1'b0; ba_cap_n = 1'b1;
    #1;
    check_ports("R1 second reset ones", 1'b1, 8'hFF, 1'b1, 8'hFF);

    // R2/R3: one-cycle capture then hold value from the last open edge
    @(negedge clk);
    ab_oe_n = 1'b1; ab_cap_n = 1'b0; a_in = 8'h69;
    @(posedge clk); #2;
    @(negedge clk);
    ab_cap_n = 1'b1; ab_oe_n = 1'b0; a_in = 8'h00;
    @(posedge clk); #2;
    check("R3 held value after capture rise", b_out, 8'h96);
    check("R7 B-to-A untouched", a_out, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule